// File: doc/BRIEF.md
# Serial Activity Lock Monitor

This block watches a recovered serial bit stream, one bit per clock, and judges whether clock recovery on that stream can be trusted. It keeps two statistics over the bits it accepts. The first is the length of the current run of identical bits. The second is the number of transitions in consecutive fixed windows of `WIN_BITS` bits. From these statistics it drives a lock indicator and a registered clock-source select. The select chooses between the clock derived from the data and the local reference clock.

Behaviour is organised as a three-state machine:

- **REF_INIT**: reference-lock holding. The select points at the reference clock. A cycle counter runs for `INIT_CYCLES` cycles.
- **ACQUIRE**: the select points at the data clock. The block counts bits that arrive without a violation.
- **LOCKED**: lock is reported.

The machine has these transitions:

- **init_done**: REF_INIT to ACQUIRE, when the counter expires.
- **acq_done**: ACQUIRE to LOCKED, after `ACQ_BITS` clean bits.
- **violation**: ACQUIRE or LOCKED back to REF_INIT, on an overlong run or on a window with too few transitions.
- **forced**: any state to REF_INIT, while the active-low force input is low.

On a violation the monitor returns to the reference clock and starts a new acquisition attempt, which begins with a fresh holding interval.

Top module: `serial_lock_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `locked` is 0 and `sel_data` is 0 (0 selects the reference clock, 1 the data clock).
- R2: After reset, `sel_data` stays 0 for exactly `INIT_CYCLES` rising edges (init_done) and then becomes 1, with `locked` still 0.
- R3: In ACQUIRE, `locked` rises on the edge that accepts the `ACQ_BITS`-th bit (default 250) of the attempt, provided no violation occurred, and not earlier.
- R4: A run of more than `MAX_RUN` identical bits (default 64) is a violation. On the edge that accepts the (`MAX_RUN`+1)-th identical bit, `locked` and `sel_data` both go to 0. A run of exactly `MAX_RUN` bits is not a violation.
- R5: Transitions are counted in back-to-back windows of `WIN_BITS` bits (default 100), aligned to the first bit of an attempt. That first bit never counts as a transition. On the last bit of a window, a total below `MIN_TRANS` (default 12) is a violation, and `locked` and `sel_data` go to 0 on that edge. Exactly `MIN_TRANS` transitions is not a violation.
- R6: A single phase slip does not drop `locked` when the run and density limits are still met. A phase slip here means one repeated bit inside an alternating pattern.
- R7: After a violation the monitor holds REF_INIT for `INIT_CYCLES` edges and then starts a new acquisition with `sel_data` = 1 and `locked` = 0.
- R8: While `force_ref_n` is 0, from any state, `locked` and `sel_data` go to 0 on the next edge and the holding counter restarts. The full `INIT_CYCLES` interval is counted only after `force_ref_n` returns to 1.
- R9: `locked` is never 1 while `sel_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Sampled serial bit |
| force_ref_n | input | 1 | Active-low hold in reference-lock state |
| locked | output | 1 | Lock indicator |
| sel_data | output | 1 | Registered clock-source select: 1 data clock, 0 reference clock |

## Verification
An alternating pattern reaches lock on exactly the 250th bit. The same pattern, with one repeated bit inserted, shows that a phase slip is tolerated. A following constant run of 65 bits separates the 64-bit limit from the 65-bit limit. Square waves with runs of 9 and of 8 give 11 and 12 transitions per window, which pins the density threshold at its exact boundary without ever breaking the run limit. Asserting the force input inside the holding interval, during acquisition and while locked shows that it overrides every state and restarts the holding count.

// File: rtl/lm_pkg.sv
package lm_pkg;
    typedef enum logic [1:0] {
        ST_REF_INIT = 2'd0,
        ST_ACQUIRE  = 2'd1,
        ST_LOCKED   = 2'd2
    } lm_state_e;
endpackage

// File: rtl/lm_run_tracker.sv
// Tracks the length of the current run of identical bits and flags a transition.
module lm_run_tracker #(
    parameter int MAX_RUN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_in,
    output logic run_viol,
    output logic toggle
);
    localparam int RUN_W = $clog2(MAX_RUN + 2);

    logic             prev_q;
    logic             have_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_next;
    logic             same;

    always_comb begin
        same   = have_q && (bit_in == prev_q);
        toggle = have_q && (bit_in != prev_q);
        if (same) begin
            run_next = (run_q == RUN_W'(MAX_RUN + 1)) ? run_q : run_q + RUN_W'(1);
        end else begin
            run_next = RUN_W'(1);
        end
        run_viol = run_next > RUN_W'(MAX_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            run_q  <= '0;
        end else if (clear) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= bit_in;
            have_q <= 1'b1;
            run_q  <= run_next;
        end
    end
endmodule

// File: rtl/lm_density_window.sv
// Counts transitions in back-to-back windows and flags a sparse window on its last bit.
module lm_density_window #(
    parameter int WIN_BITS  = 100,
    parameter int MIN_TRANS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic toggle,
    output logic dens_viol
);
    localparam int WIN_W = $clog2(WIN_BITS);
    localparam int TR_W  = $clog2(WIN_BITS + 1);

    logic [WIN_W-1:0] win_q;
    logic [TR_W-1:0]  trans_q;
    logic [TR_W-1:0]  trans_total;
    logic             win_last;

    always_comb begin
        trans_total = trans_q + TR_W'(toggle);
        win_last    = (win_q == WIN_W'(WIN_BITS - 1));
        dens_viol   = win_last && (trans_total < TR_W'(MIN_TRANS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            trans_q <= '0;
        end else if (clear || win_last) begin
            win_q   <= '0;
            trans_q <= '0;
        end else begin
            win_q   <= win_q + WIN_W'(1);
            trans_q <= trans_total;
        end
    end
endmodule

// File: rtl/lm_lock_fsm.sv
// Reference-hold / acquire / locked sequencing with registered outputs.
module lm_lock_fsm
    import lm_pkg::*;
#(
    parameter int INIT_CYCLES = 10_625_000,
    parameter int ACQ_BITS    = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_ref_n,
    input  logic run_viol,
    input  logic dens_viol,
    output logic stats_clear,
    output logic locked,
    output logic sel_data
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam int ACQ_W  = $clog2(ACQ_BITS + 1);

    lm_state_e         state_q;
    lm_state_e         state_next;
    logic [INIT_W-1:0] init_q;
    logic [ACQ_W-1:0]  acq_q;
    logic              active;
    logic              viol;

    always_comb begin
        active      = (state_q == ST_ACQUIRE) || (state_q == ST_LOCKED);
        stats_clear = !active;
        viol        = active && (run_viol || dens_viol);
        state_next  = state_q;
        unique case (state_q)
            ST_REF_INIT: begin
                if (init_q == INIT_W'(INIT_CYCLES - 1)) state_next = ST_ACQUIRE;   // init_done
            end
            ST_ACQUIRE: begin
                if (viol)                              state_next = ST_REF_INIT; // violation
                else if (acq_q == ACQ_W'(ACQ_BITS - 1)) state_next = ST_LOCKED;  // acq_done
            end
            ST_LOCKED: begin
                if (viol) state_next = ST_REF_INIT;                              // violation
            end
            default: state_next = ST_REF_INIT;
        endcase
        if (!force_ref_n) state_next = ST_REF_INIT;                              // forced
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_REF_INIT;
        else        state_q <= state_next;
    end

    // Holding and acquisition counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= '0;
            acq_q  <= '0;
        end else begin
            init_q <= (state_q == ST_REF_INIT && force_ref_n) ? init_q + INIT_W'(1) : '0;
            acq_q  <= (state_q == ST_ACQUIRE) ? acq_q + ACQ_W'(1) : '0;
        end
    end

    // Outputs registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            sel_data <= 1'b0;
        end else begin
            locked   <= (state_next == ST_LOCKED);
            sel_data <= (state_next != ST_REF_INIT);
        end
    end
endmodule

// File: rtl/serial_lock_monitor.sv
module serial_lock_monitor #(
    parameter int INIT_CYCLES = 10_625_000,
    parameter int ACQ_BITS    = 250,
    parameter int MAX_RUN     = 64,
    parameter int WIN_BITS    = 100,
    parameter int MIN_TRANS   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic force_ref_n,
    output logic locked,
    output logic sel_data
);
    logic stats_clear;
    logic run_viol;
    logic dens_viol;
    logic toggle;

    lm_run_tracker #(.MAX_RUN(MAX_RUN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stats_clear),
        .bit_in   (data_in),
        .run_viol (run_viol),
        .toggle   (toggle)
    );

    lm_density_window #(.WIN_BITS(WIN_BITS), .MIN_TRANS(MIN_TRANS)) u_dens (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (stats_clear),
        .toggle    (toggle),
        .dens_viol (dens_viol)
    );

    lm_lock_fsm #(.INIT_CYCLES(INIT_CYCLES), .ACQ_BITS(ACQ_BITS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_ref_n (force_ref_n),
        .run_viol    (run_viol),
        .dens_viol   (dens_viol),
        .stats_clear (stats_clear),
        .locked      (locked),
        .sel_data    (sel_data)
    );
endmodule

// File: rtl/lm_lock_checker.sv
module lm_lock_checker #(
    parameter int INIT_CYCLES = 10_625_000,
    parameter int ACQ_BITS    = 250,
    parameter int MAX_RUN     = 64
) (
    input logic clk,
    input logic rst_n,
    input logic data_in,
    input logic force_ref_n,
    input logic locked,
    input logic sel_data
);
    logic [31:0] ref_cnt;
    logic [31:0] data_cnt;
    logic [31:0] run_c;
    logic        prev_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt  <= '0;
            data_cnt <= '0;
            run_c    <= '0;
            prev_c   <= 1'b0;
        end else begin
            ref_cnt  <= sel_data ? '0 : ((ref_cnt == 32'hFFFF_FFFF) ? ref_cnt : ref_cnt + 32'd1);
            data_cnt <= !sel_data ? '0 : ((data_cnt == 32'hFFFF_FFFF) ? data_cnt : data_cnt + 32'd1);
            prev_c   <= data_in;
            if (!sel_data)                         run_c <= '0;
            else if (run_c == '0 || data_in != prev_c) run_c <= 32'd1;
            else if (run_c != 32'hFFFF_FFFF)        run_c <= run_c + 32'd1;
        end
    end

    assert_init_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_data) |-> (ref_cnt >= 32'(INIT_CYCLES)));

    assert_lock_after_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (data_cnt >= 32'(ACQ_BITS)));

    assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (run_c <= 32'(MAX_RUN)));

    assert_force_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !force_ref_n |=> (!sel_data && !locked));

    assert_lock_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> sel_data);
endmodule

bind serial_lock_monitor lm_lock_checker #(
    .INIT_CYCLES (INIT_CYCLES),
    .ACQ_BITS    (ACQ_BITS),
    .MAX_RUN     (MAX_RUN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_in     (data_in),
    .force_ref_n (force_ref_n),
    .locked      (locked),
    .sel_data    (sel_data)
);

// File: tb/sim_serial_lock_monitor.sv
module sim_serial_lock_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int INIT = 20;
    localparam int ACQ  = 250;

    typedef struct {
        logic  lock;
        logic  sel;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic force_ref_n = 1'b1;
    logic locked;
    logic sel_data;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    serial_lock_monitor #(
        .INIT_CYCLES (INIT),
        .ACQ_BITS    (ACQ),
        .MAX_RUN     (64),
        .WIN_BITS    (100),
        .MIN_TRANS   (12)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (data_in),
        .force_ref_n (force_ref_n),
        .locked      (locked),
        .sel_data    (sel_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one bit and queue the outputs expected after the next edge
    task automatic step(input logic b, input logic fr, input logic el, input logic es, input string req);
        exp_t e;
        @(negedge clk);
        data_in     = b;
        force_ref_n = fr;
        e.lock = el;
        e.sel  = es;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // Holding interval: select rises on its last edge
    task automatic init_phase(input string req);
        for (int k = 0; k < INIT; k++) step(1'b0, 1'b1, 1'b0, (k == INIT - 1), req);
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (locked !== e.lock || sel_data !== e.sel) begin
                    n_bad++;
                    $display("FAIL %s: locked=%b sel_data=%b expected locked=%b sel_data=%b",
                             e.req, locked, sel_data, e.lock, e.sel);
                end else if (locked === 1'b1 && sel_data !== 1'b1) begin
                    n_bad++;   // R9
                    $display("FAIL R9: locked=%b sel_data=%b expected sel_data=1", locked, sel_data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_vec++;
        if (locked !== 1'b0 || sel_data !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: locked=%b sel_data=%b expected 0 0", locked, sel_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.push_back('{1'b0, 1'b0, "R1"});

        // R2: holding interval after reset; first queued item above covers edge 0
        for (int k = 1; k < INIT; k++) step(1'b0, 1'b1, 1'b0, (k == INIT - 1), "R2");

        // Alternating data, phase slip, then a 65-bit constant run (R3, R6, R4)
        for (int j = 0; j <= 374; j++) begin
            logic b;
            string r;
            if (j < 260)      b = j[0];
            else if (j < 310) b = !j[0];
            else              b = 1'b1;
            r = (j < 260) ? "R3" : (j < 310) ? "R6" : "R4";
            step(b, 1'b1, (j >= ACQ - 1 && j < 374), (j < 374), r);
        end

        // R7: new attempt after the violation
        init_phase("R7");

        // R5: runs of 9 give 11 transitions in the first window -> violation at bit 99
        for (int j = 0; j < 100; j++) step(1'(j / 9), 1'b1, 1'b0, (j < 99), "R5");

        init_phase("R7");

        // R5 boundary: runs of 8 give 12 transitions per window -> no violation; R3 lock at 249
        for (int j = 0; j < 260; j++) step(1'(j / 8), 1'b1, (j >= ACQ - 1), 1'b1, (j < 200) ? "R5" : "R3");

        // R8: force while locked
        for (int k = 0; k < 5; k++) step(1'(k), 1'b0, 1'b0, 1'b0, "R8");
        init_phase("R8");
        // R8: force during acquisition
        for (int j = 0; j < 10; j++) step(1'(j), 1'b1, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        // R8: force inside the holding interval restarts the count
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        init_phase("R8");
        for (int j = 0; j < 5; j++) step(1'(j), 1'b1, 1'b0, 1'b1, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule